// File: doc/BRIEF.md
# USB Transmit Endpoint Packet Controller

This block keeps the packet-level state of one USB transmit endpoint, on either the device side or the host side of the link. Software programs it through a byte-wide control register. Producer logic, meaning the processor or a DMA engine, writes bytes toward the endpoint FIFO through a write-strobe port. The block counts the bytes it accepts and raises a packet-ready flag for the serial engine. Software can raise that flag for any packet size. With the auto-arm option enabled, the block raises it by itself once the loaded count reaches the programmed maximum packet size exactly.

The block keeps the DATA0/DATA1 toggle. The toggle advances when the serial engine reports a completed, acknowledged packet, except on isochronous endpoints, where there is no handshake. Software can also force the toggle to advance. A forced toggle discards the pending packet and pulses a FIFO flush, whatever the handshake state. The block also drives a DMA request line in one of two pacing modes. It flags writes that arrive while a packet is already armed, and it drops those writes.

Top module: `txep_pkt_ctrl`

## Requirements
- R1: After reset, the control readback, packet-ready, byte count, data toggle, DMA request, overrun flag and flush output are all 0.
- R2: With auto-arm (control bit 7) set and a nonzero maximum size, the accepted write that brings the byte count equal to the maximum size sets packet-ready at that same clock edge. Fewer bytes leave packet-ready clear.
- R3: Packets shorter than the maximum size are never armed automatically. A one-cycle `sw_arm` pulse sets packet-ready.
- R4: A maximum packet size of 0 disables auto-arm, whatever the byte count.
- R5: When `pkt_done` is asserted while packet-ready is set, packet-ready clears, the byte count returns to 0, and the data toggle inverts on non-isochronous endpoints.
- R6: The isochronous bit (control bit 6) takes effect only when `host_mode` is 0. While isochronous is in effect, `pkt_done` leaves the toggle unchanged. In host mode, bit 6 reads back as 0 and completion inverts the toggle.
- R7: A control write with bit 3 set inverts the toggle, clears the byte count and packet-ready, and raises `fifo_flush` for exactly the following cycle, regardless of any handshake. Bit 3 always reads back as 0.
- R8: A FIFO write that arrives while packet-ready is set is not forwarded on `fifo_push` and does not change the count. It sets a sticky overrun flag, which a `ovr_clr` pulse clears.
- R9: `dma_req` is 0 while the DMA enable (bit 4) is clear. In mode 0 (bit 2 = 0), it is 1 only when packet-ready is clear and the count is 0. In mode 1 (bit 2 = 1), it is 1 while packet-ready is clear and the count is below the maximum size.
- R10: With a shared FIFO, the direction bit (bit 5) selects transmit (1) or receive (0). `ep_is_tx` follows the bit, and no DMA request is raised while the endpoint is in receive mode.
- R11: Clearing the DMA mode bit while the DMA enable stays set is an illegal control write. Clearing both in the same write is legal.
- R12: Control bits 7, 5, 4 and 2 read back exactly as written. Bits 1 and 0 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| max_pkt | input | CNT_W | Maximum packet size in bytes |
| fifo_wr_en | input | 1 | Producer byte write strobe |
| fifo_push | output | 1 | Accepted write forwarded to the FIFO |
| fifo_flush | output | 1 | One-cycle FIFO discard pulse |
| sw_arm | input | 1 | Software packet-ready request |
| pkt_done | input | 1 | Engine reports packet completed (ACK, or sent if isochronous) |
| ovr_clr | input | 1 | Clears the overrun flag |
| pkt_rdy | output | 1 | Packet armed for transmission |
| byte_cnt | output | CNT_W | Bytes loaded in the current packet |
| data_tog | output | 1 | Current data toggle (0 = DATA0) |
| dma_req | output | 1 | DMA request |
| overrun | output | 1 | Sticky overrun flag |
| ep_is_tx | output | 1 | Endpoint currently in transmit direction |

## Verification
The checker tests the following on every cycle:
- a write that fills a packet with auto-arm on arms it at the next edge;
- no FIFO push while armed, and overrun is set after a write that was dropped;
- a forced toggle flips the toggle, empties the count and pulses the flush;
- isochronous completions keep the toggle, and bit 6 reads back as 0 in host mode;
- the request line stays low while DMA is disabled or the endpoint is in receive direction;
- every control write keeps the mode/enable ordering legal.

Some behaviour needs whole packet sequences, so only the bench scenarios cover it:
- the sweep of every maximum size from 0 to the limit, with the exact byte at which arming happens;
- the manual arming of short packets;
- the running toggle value across many packets;
- the rise and fall of the request line through a packet in each DMA mode.

// File: rtl/txep_pkg.sv
package txep_pkg;
   // Control register bit positions (software decodes these)
   localparam int unsigned BIT_AUTO   = 7;
   localparam int unsigned BIT_ISO    = 6;
   localparam int unsigned BIT_DIR    = 5;
   localparam int unsigned BIT_DMAEN  = 4;
   localparam int unsigned BIT_FORCE  = 3;
   localparam int unsigned BIT_DMAMOD = 2;

   typedef struct packed {
      logic auto_arm;
      logic iso;
      logic dir_tx;
      logic dma_en;
      logic dma_mode;
   } ctl_fields_t;
endpackage

// File: rtl/txep_ctl_regs.sv
module txep_ctl_regs
   import txep_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_mode,
   input  logic        ctl_wr_en,
   input  logic [7:0]  ctl_wdata,
   output ctl_fields_t fields,
   output logic        iso_eff,
   output logic        force_now,
   output logic [7:0]  ctl_rdata
);
   ctl_fields_t f_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_q <= '0;
      end else if (ctl_wr_en) begin
         f_q.auto_arm <= ctl_wdata[BIT_AUTO];
         f_q.iso      <= ctl_wdata[BIT_ISO];
         f_q.dir_tx   <= ctl_wdata[BIT_DIR];
         f_q.dma_en   <= ctl_wdata[BIT_DMAEN];
         f_q.dma_mode <= ctl_wdata[BIT_DMAMOD];
      end
   end

   assign fields    = f_q;
   assign iso_eff   = f_q.iso & ~host_mode;
   assign force_now = ctl_wr_en & ctl_wdata[BIT_FORCE];

   always_comb begin
      ctl_rdata             = '0;
      ctl_rdata[BIT_AUTO]   = f_q.auto_arm;
      ctl_rdata[BIT_ISO]    = iso_eff;
      ctl_rdata[BIT_DIR]    = f_q.dir_tx;
      ctl_rdata[BIT_DMAEN]  = f_q.dma_en;
      ctl_rdata[BIT_DMAMOD] = f_q.dma_mode;
   end
endmodule

// File: rtl/txep_pkt_track.sv
module txep_pkt_track #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_arm,
   input  logic [CNT_W-1:0] max_pkt,
   input  logic             force_now,
   input  logic             fifo_wr_en,
   input  logic             sw_arm,
   input  logic             pkt_done,
   input  logic             ovr_clr,
   output logic             fifo_push,
   output logic             fifo_flush,
   output logic             pkt_rdy,
   output logic [CNT_W-1:0] byte_cnt,
   output logic             overrun,
   output logic             done_ok
);
   logic [CNT_W-1:0] cnt_q;
   logic             rdy_q, ovr_q, flush_q;
   logic [CNT_W:0]   next_cnt;
   logic             fills;
   logic             cnt_sat;

   assign fifo_push = fifo_wr_en & ~rdy_q & ~force_now;
   assign done_ok   = pkt_done & rdy_q;
   assign next_cnt  = {1'b0, cnt_q} + 1'b1;
   assign cnt_sat   = &cnt_q;
   assign fills     = auto_arm & (max_pkt != '0) & (next_cnt == {1'b0, max_pkt});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rdy_q <= 1'b0;
      end else if (force_now || done_ok) begin
         cnt_q <= '0;
         rdy_q <= 1'b0;
      end else begin
         if (fifo_push && !cnt_sat) cnt_q <= next_cnt[CNT_W-1:0];
         if ((fifo_push && fills) || sw_arm) rdy_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q   <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= force_now;
         if (fifo_wr_en && rdy_q) ovr_q <= 1'b1;
         else if (ovr_clr)        ovr_q <= 1'b0;
      end
   end

   assign pkt_rdy    = rdy_q;
   assign byte_cnt   = cnt_q;
   assign overrun    = ovr_q;
   assign fifo_flush = flush_q;
endmodule

// File: rtl/txep_toggle.sv
module txep_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic force_now,
   input  logic done_ok,
   input  logic iso_eff,
   output logic data_tog
);
   logic tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                              tog_q <= 1'b0;
      else if (force_now || (done_ok && !iso_eff)) tog_q <= ~tog_q;
   end

   assign data_tog = tog_q;
endmodule

// File: rtl/txep_dma_req.sv
module txep_dma_req #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             dma_en,
   input  logic             dma_mode,
   input  logic             ep_is_tx,
   input  logic             pkt_rdy,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic [CNT_W-1:0] max_pkt,
   output logic             dma_req
);
   logic room;

   always_comb begin
      if (dma_mode) room = (byte_cnt < max_pkt);
      else          room = (byte_cnt == '0);
   end

   assign dma_req = dma_en & ep_is_tx & ~pkt_rdy & room;
endmodule

// File: rtl/txep_pkt_ctrl.sv
module txep_pkt_ctrl
   import txep_pkg::*;
#(
   parameter int unsigned MAX_PKT_LIMIT = 64,
   parameter bit          SHARED_FIFO   = 1'b1,
   localparam int unsigned CNT_W        = $clog2(MAX_PKT_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_mode,
   input  logic             ctl_wr_en,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   input  logic [CNT_W-1:0] max_pkt,
   input  logic             fifo_wr_en,
   output logic             fifo_push,
   output logic             fifo_flush,
   input  logic             sw_arm,
   input  logic             pkt_done,
   input  logic             ovr_clr,
   output logic             pkt_rdy,
   output logic [CNT_W-1:0] byte_cnt,
   output logic             data_tog,
   output logic             dma_req,
   output logic             overrun,
   output logic             ep_is_tx
);
   initial begin
      if (MAX_PKT_LIMIT < 1 || MAX_PKT_LIMIT > 1024)
         $error("txep_pkt_ctrl: MAX_PKT_LIMIT must lie in 1..1024");
   end

   ctl_fields_t fields;
   logic        iso_eff, force_now, done_ok;

   txep_ctl_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_mode (host_mode),
      .ctl_wr_en (ctl_wr_en),
      .ctl_wdata (ctl_wdata),
      .fields    (fields),
      .iso_eff   (iso_eff),
      .force_now (force_now),
      .ctl_rdata (ctl_rdata)
   );

   txep_pkt_track #(.CNT_W(CNT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_arm   (fields.auto_arm),
      .max_pkt    (max_pkt),
      .force_now  (force_now),
      .fifo_wr_en (fifo_wr_en),
      .sw_arm     (sw_arm),
      .pkt_done   (pkt_done),
      .ovr_clr    (ovr_clr),
      .fifo_push  (fifo_push),
      .fifo_flush (fifo_flush),
      .pkt_rdy    (pkt_rdy),
      .byte_cnt   (byte_cnt),
      .overrun    (overrun),
      .done_ok    (done_ok)
   );

   txep_toggle u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_now (force_now),
      .done_ok   (done_ok),
      .iso_eff   (iso_eff),
      .data_tog  (data_tog)
   );

   generate
      if (SHARED_FIFO) begin : g_shared
         assign ep_is_tx = fields.dir_tx;
      end else begin : g_dedicated
         assign ep_is_tx = 1'b1;
      end
   endgenerate

   txep_dma_req #(.CNT_W(CNT_W)) u_dma (
      .dma_en   (fields.dma_en),
      .dma_mode (fields.dma_mode),
      .ep_is_tx (ep_is_tx),
      .pkt_rdy  (pkt_rdy),
      .byte_cnt (byte_cnt),
      .max_pkt  (max_pkt),
      .dma_req  (dma_req)
   );
endmodule

// File: rtl/txep_pkt_ctrl_checker.sv
module txep_pkt_ctrl_checker #(
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_mode,
   input logic             ctl_wr_en,
   input logic [7:0]       ctl_wdata,
   input logic [7:0]       ctl_rdata,
   input logic [CNT_W-1:0] max_pkt,
   input logic             fifo_wr_en,
   input logic             fifo_push,
   input logic             fifo_flush,
   input logic             pkt_done,
   input logic             pkt_rdy,
   input logic [CNT_W-1:0] byte_cnt,
   input logic             data_tog,
   input logic             dma_req,
   input logic             overrun,
   input logic             ep_is_tx
);
   logic force_w;
   assign force_w = ctl_wr_en & ctl_wdata[3];

   assert_autoset_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && ctl_rdata[7] && max_pkt != '0 &&
       ({1'b0, byte_cnt} + 1'b1) == {1'b0, max_pkt} && !pkt_done)
      |=> pkt_rdy);

   assert_zero_max_no_auto_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (max_pkt == '0 && $stable(max_pkt) && fifo_push) |=> !pkt_rdy || $past(pkt_rdy));

   assert_no_push_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_rdy |-> !fifo_push);

   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_en && pkt_rdy) |=> overrun);

   assert_force_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
      force_w |=> (data_tog != $past(data_tog)) && fifo_flush && byte_cnt == '0 && !pkt_rdy);

   assert_iso_keeps_tog_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && ctl_rdata[6] && !force_w) |=> $stable(data_tog));

   assert_host_iso_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_mode |-> !ctl_rdata[6]);

   assert_dma_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[4] || !ep_is_tx || pkt_rdy) |-> !dma_req);

   assert_mode_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_en && ctl_rdata[4] && ctl_rdata[2] && !ctl_wdata[2]) |-> !ctl_wdata[4]);
endmodule

bind txep_pkt_ctrl txep_pkt_ctrl_checker #(.CNT_W(CNT_W)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_mode  (host_mode),
   .ctl_wr_en  (ctl_wr_en),
   .ctl_wdata  (ctl_wdata),
   .ctl_rdata  (ctl_rdata),
   .max_pkt    (max_pkt),
   .fifo_wr_en (fifo_wr_en),
   .fifo_push  (fifo_push),
   .fifo_flush (fifo_flush),
   .pkt_done   (pkt_done),
   .pkt_rdy    (pkt_rdy),
   .byte_cnt   (byte_cnt),
   .data_tog   (data_tog),
   .dma_req    (dma_req),
   .overrun    (overrun),
   .ep_is_tx   (ep_is_tx)
);

// File: tb/txep_pkt_ctrl_tb.sv
`timescale 1ns/1ps
module txep_pkt_ctrl_tb_top;
   localparam int unsigned LIM = 8;
   localparam int unsigned CW  = $clog2(LIM + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_mode = 1'b0;
   logic          ctl_wr_en = 1'b0;
   logic [7:0]    ctl_wdata = '0;
   logic [7:0]    ctl_rdata;
   logic [CW-1:0] max_pkt = '0;
   logic          fifo_wr_en = 1'b0;
   logic          fifo_push, fifo_flush;
   logic          sw_arm = 1'b0, pkt_done = 1'b0, ovr_clr = 1'b0;
   logic          pkt_rdy, data_tog, dma_req, overrun, ep_is_tx;
   logic [CW-1:0] byte_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   int exp_tog = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   txep_pkt_ctrl #(.MAX_PKT_LIMIT(LIM), .SHARED_FIFO(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
      .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .max_pkt(max_pkt), .fifo_wr_en(fifo_wr_en), .fifo_push(fifo_push),
      .fifo_flush(fifo_flush), .sw_arm(sw_arm), .pkt_done(pkt_done),
      .ovr_clr(ovr_clr), .pkt_rdy(pkt_rdy), .byte_cnt(byte_cnt),
      .data_tog(data_tog), .dma_req(dma_req), .overrun(overrun),
      .ep_is_tx(ep_is_tx)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      ctl_wr_en = 1'b0; fifo_wr_en = 1'b0; sw_arm = 1'b0;
      pkt_done = 1'b0; ovr_clr = 1'b0;
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr_en = 1'b1; ctl_wdata = v;
      step();
   endtask

   task automatic push1();
      fifo_wr_en = 1'b1;
      step();
   endtask

   task automatic finish_pkt(input bit iso_active);
      pkt_done = 1'b1;
      step();
      if (!iso_active) exp_tog ^= 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check("R1 rdata", int'(ctl_rdata), 0);
      check("R1 pkt_rdy", int'(pkt_rdy), 0);
      check("R1 cnt", int'(byte_cnt), 0);
      check("R1 tog", int'(data_tog), 0);
      check("R1 dma", int'(dma_req), 0);
      check("R1 ovr", int'(overrun), 0);
      check("R1 flush", int'(fifo_flush), 0);

      // R2/R4 sweep of every maximum size, auto-arm + tx direction
      wr_ctl(8'hA0);
      check("R12 rdata auto", int'(ctl_rdata), 'hA0);
      for (int m = 0; m <= int'(LIM); m++) begin
         max_pkt = CW'(m);
         for (int k = 1; k <= int'(LIM); k++) begin
            push1();
            check(m == 0 ? "R4 no auto at max0" : "R2 arm at exact max",
                  int'(pkt_rdy), (m != 0 && k == m) ? 1 : 0);
            check("R2 count", int'(byte_cnt), k);
            if (m != 0 && k == m) break;
         end
         if (!pkt_rdy) begin
            sw_arm = 1'b1; step();
            check("R3 sw arm", int'(pkt_rdy), 1);
         end
         finish_pkt(1'b0);
         check("R5 rdy clr", int'(pkt_rdy), 0);
         check("R5 cnt clr", int'(byte_cnt), 0);
         check("R5 toggle", int'(data_tog), exp_tog);
         check("R8 no overrun", int'(overrun), 0);
      end

      // R3 short packet + R8 overrun
      max_pkt = 4;
      push1(); push1();
      check("R3 short no auto", int'(pkt_rdy), 0);
      sw_arm = 1'b1; step();
      check("R3 sw arm short", int'(pkt_rdy), 1);
      fifo_wr_en = 1'b1; #1;
      check("R8 push blocked", int'(fifo_push), 0);
      step();
      check("R8 count kept", int'(byte_cnt), 2);
      check("R8 overrun set", int'(overrun), 1);
      step();
      check("R8 overrun sticky", int'(overrun), 1);
      ovr_clr = 1'b1; step();
      check("R8 overrun clr", int'(overrun), 0);
      finish_pkt(1'b0);
      check("R5 toggle short", int'(data_tog), exp_tog);

      // R6 isochronous in device and host modes
      wr_ctl(8'h60);
      check("R6 iso readback dev", int'(ctl_rdata), 'h60);
      sw_arm = 1'b1; step();
      finish_pkt(1'b1);
      check("R6 iso keeps tog", int'(data_tog), exp_tog);
      check("R6 iso rdy clr", int'(pkt_rdy), 0);
      host_mode = 1'b1; #1;
      check("R6 iso reads 0 host", int'(ctl_rdata), 'h20);
      sw_arm = 1'b1; step();
      finish_pkt(1'b0);
      check("R6 host toggles", int'(data_tog), exp_tog);
      host_mode = 1'b0;

      // R7 forced toggle and flush
      wr_ctl(8'h20);
      push1(); push1(); push1();
      check("R7 pre count", int'(byte_cnt), 3);
      wr_ctl(8'h28); exp_tog ^= 1;
      check("R7 tog flip", int'(data_tog), exp_tog);
      check("R7 cnt clr", int'(byte_cnt), 0);
      check("R7 flush", int'(fifo_flush), 1);
      check("R7 reads 0", int'(ctl_rdata), 'h20);
      step();
      check("R7 flush one cycle", int'(fifo_flush), 0);
      sw_arm = 1'b1; step();
      wr_ctl(8'h28); exp_tog ^= 1;
      check("R7 discard armed", int'(pkt_rdy), 0);
      check("R7 tog no ack", int'(data_tog), exp_tog);

      // R9 DMA mode 0
      wr_ctl(8'h30);
      check("R9 mode0 empty", int'(dma_req), 1);
      push1();
      check("R9 mode0 partial", int'(dma_req), 0);
      wr_ctl(8'h38); exp_tog ^= 1;
      check("R9 mode0 after flush", int'(dma_req), 1);
      // R9 DMA mode 1, max 4
      wr_ctl(8'h34);
      for (int k = 1; k <= 4; k++) begin
         push1();
         check("R9 mode1 req", int'(dma_req), (k < 4) ? 1 : 0);
      end
      sw_arm = 1'b1; step();
      check("R9 mode1 armed", int'(dma_req), 0);
      finish_pkt(1'b0);
      check("R9 mode1 refill", int'(dma_req), 1);
      // R11 legal disable: enable and mode cleared together
      wr_ctl(8'h20);
      check("R11 both cleared", int'(dma_req), 0);
      check("R9 disabled", int'(ctl_rdata), 'h20);

      // R10 direction
      wr_ctl(8'h10);
      check("R10 rx dir", int'(ep_is_tx), 0);
      check("R10 no dma rx", int'(dma_req), 0);
      wr_ctl(8'h30);
      check("R10 tx dir", int'(ep_is_tx), 1);
      check("R10 dma tx", int'(dma_req), 1);

      // R12 full readback
      wr_ctl(8'hF7);
      check("R12 readback", int'(ctl_rdata), 'hF4);
      host_mode = 1'b1; #1;
      check("R12 readback host", int'(ctl_rdata), 'hB4);
      host_mode = 1'b0;
      wr_ctl(8'h00);
      check("R12 cleared", int'(ctl_rdata), 0);
      check("R5 final tog", int'(data_tog), exp_tog);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule